// File: doc/BRIEF.md
# Dual-Register Direct Digital Synthesis Waveform Core

This block is a numerically controlled oscillator that turns a master clock into a periodic 10-bit digital sample stream. It keeps two 28-bit tuning words and two 12-bit phase offsets. One select input picks the active tuning word and another picks the active offset. On every clock edge the chosen tuning word is added to a 28-bit phase accumulator. The output frequency is therefore f_clk × word / 2^28, which is a step of about 0.1 Hz at 25 MHz.

The top 12 accumulator bits plus the chosen offset form a phase word. That phase word feeds a quarter-wave sine table, which is computed at elaboration, and a triangle folder. A square mode takes the accumulator MSB directly, and a fourth mode divides that square by two. A sleep input freezes the sample register while the accumulator keeps counting. Software-side logic loads the four registers through one parallel write port, and a downstream converter takes `sample_o`.

Top module: `dds_wave_core`

## Requirements
- R1: A synchronous reset clears the accumulator, all four registers, the divide toggle and the sample. After the reset edge, `phase_acc_o` is 0 and `sample_o` is 0.
- R2: On each clock edge out of reset, the accumulator gains the selected tuning word modulo 2^28. A tuning word of zero leaves it unchanged.
- R3: When `wr_en` is high, `wr_addr` picks the target register: 0 = tuning word A, 1 = tuning word B, 2 = offset A, 3 = offset B. Offsets take `wr_data[11:0]`. The register holds the new value after that edge, and the accumulator first uses it on the following edge.
- R4: `freq_sel` = 0 adds tuning word A and 1 adds tuning word B. A change of the select applies from the next edge.
- R5: The phase word is (`phase_acc_o[27:16]` + selected offset) mod 4096. `phase_sel` = 0 picks offset A and 1 picks offset B.
- R6: Mode 0 (sine). Let q = phase word bits [11:10] and i = bits [9:0]. If q[0] is set, i becomes 1023 − i. Then m = round(511·sin(π(2i+1)/4096)). The sample is 512 + m when q[1] = 0, and 511 − m otherwise.
- R7: Mode 1 (triangle) outputs phase bits [10:1]. When phase bit 11 is set, those bits are inverted first.
- R8: Mode 2 (square) outputs 1023 when the accumulator MSB before the edge was 1, and 0 otherwise.
- R9: Mode 3 (half-rate square) keeps a toggle. The toggle flips on an edge where the accumulator MSB is 1 but was 0 one cycle earlier. The sample is 1023 while the new toggle value is 1, and 0 otherwise.
- R10: While `sleep` is high, `sample_o` holds its value and the accumulator keeps advancing.
- R11: The sample registered at an edge is computed from the accumulator value, offsets, selects and mode present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register target of a write |
| wr_data | input | 28 | Write data (offsets use bits 11:0) |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 1 | Phase offset select |
| wave_mode | input | 2 | 0 sine, 1 triangle, 2 square, 3 half-rate square |
| sleep | input | 1 | Freeze the sample register |
| phase_acc_o | output | 28 | Phase accumulator value |
| sample_o | output | 10 | Digital waveform sample |

## Verification
A register write is visible in the accumulator two edges after the strobe is sampled: one edge to load the register and one edge to add it. Select, offset and mode changes reach `sample_o` one edge after they are applied. The driver predicts each edge's accumulator and sample from the requirement formulas and stamps every prediction with the cycle number of the edge that produces it. The monitor compares a prediction only after that edge has passed, sampling half a period away from it, so every latency above is checked at exactly its due cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE      = 2'd0,
        WAVE_TRIANGLE  = 2'd1,
        WAVE_SQUARE    = 2'd2,
        WAVE_SQUARE_HALF = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        TGT_TUNE_A  = 2'd0,
        TGT_TUNE_B  = 2'd1,
        TGT_OFFS_A  = 2'd2,
        TGT_OFFS_B  = 2'd3
    } wr_target_e;

    localparam real PI_R = 3.141592653589793;

endpackage

// File: rtl/dds_regfile.sv
module dds_regfile #(
    parameter int ACC_W   = 28,
    parameter int PHASE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_addr,
    input  logic [ACC_W-1:0]           wr_data,
    output logic [1:0][ACC_W-1:0]      tune_o,
    output logic [1:0][PHASE_W-1:0]    offs_o
);
    import dds_pkg::*;

    localparam int SLOTS = 2;

    typedef struct packed {
        logic [SLOTS-1:0][ACC_W-1:0]   tune;
        logic [SLOTS-1:0][PHASE_W-1:0] offs;
    } regs_t;

    regs_t r_d, r_q;
    wr_target_e tgt;

    assign tgt = wr_target_e'(wr_addr);

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (tgt)
                TGT_TUNE_A: r_d.tune[0] = wr_data;
                TGT_TUNE_B: r_d.tune[1] = wr_data;
                TGT_OFFS_A: r_d.offs[0] = wr_data[PHASE_W-1:0];
                TGT_OFFS_B: r_d.offs[1] = wr_data[PHASE_W-1:0];
                default:    r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign tune_o[g] = r_q.tune[g];
        assign offs_o[g] = r_q.offs[g];
    end

endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d     = a_q;
        a_d.acc = a_q.acc + step_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign acc_o = a_q.acc;

endmodule

// File: rtl/dds_shaper.sv
module dds_shaper #(
    parameter int PHASE_W  = 12,
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PHASE_W-1:0]  phase_i,
    input  logic                acc_msb_i,
    input  logic [1:0]          mode_i,
    input  logic                sleep_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    import dds_pkg::*;

    localparam int IDX_W  = PHASE_W - 2;
    localparam int QDEPTH = 1 << IDX_W;
    localparam int MAG_W  = SAMPLE_W - 1;
    localparam int AMP    = (1 << MAG_W) - 1;
    localparam logic [SAMPLE_W-1:0] HI_BASE = SAMPLE_W'(1 << MAG_W);
    localparam logic [SAMPLE_W-1:0] LO_BASE = SAMPLE_W'((1 << MAG_W) - 1);
    localparam int TRI_TOP = PHASE_W - 2;

    typedef logic [MAG_W-1:0] qtab_t [QDEPTH];

    function automatic qtab_t build_qtab();
        qtab_t t;
        real ang;
        for (int i = 0; i < QDEPTH; i++) begin
            ang  = PI_R * (2.0 * i + 1.0) / (4.0 * QDEPTH);
            t[i] = MAG_W'($rtoi(AMP * $sin(ang) + 0.5));
        end
        return t;
    endfunction

    localparam qtab_t QTAB = build_qtab();

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic                msb_prev;
        logic                half_tog;
    } shp_t;

    shp_t s_d, s_q;
    wave_e mode;

    logic [1:0]          quad;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    fold_idx;
    logic [MAG_W-1:0]    mag;
    logic [SAMPLE_W-1:0] sine_v;
    logic [SAMPLE_W-1:0] tri_raw;
    logic [SAMPLE_W-1:0] tri_v;
    logic                msb_rise;
    logic [SAMPLE_W-1:0] wave_v;

    assign mode = wave_e'(mode_i);

    // Sine from the quarter table, mirrored and flipped by quadrant
    always_comb begin
        quad     = phase_i[PHASE_W-1 -: 2];
        idx      = phase_i[IDX_W-1:0];
        fold_idx = quad[0] ? ~idx : idx;
        mag      = QTAB[fold_idx];
        if (quad[1]) begin
            sine_v = LO_BASE - {1'b0, mag};
        end else begin
            sine_v = HI_BASE + {1'b0, mag};
        end
    end

    // Triangle folded on the phase MSB
    always_comb begin
        tri_raw = phase_i[TRI_TOP -: SAMPLE_W];
        tri_v   = phase_i[PHASE_W-1] ? ~tri_raw : tri_raw;
    end

    always_comb begin
        s_d          = s_q;
        msb_rise     = acc_msb_i & ~s_q.msb_prev;
        s_d.msb_prev = acc_msb_i;
        s_d.half_tog = s_q.half_tog ^ msb_rise;
        unique case (mode)
            WAVE_SINE:        wave_v = sine_v;
            WAVE_TRIANGLE:    wave_v = tri_v;
            WAVE_SQUARE:      wave_v = {SAMPLE_W{acc_msb_i}};
            WAVE_SQUARE_HALF: wave_v = {SAMPLE_W{s_d.half_tog}};
            default:          wave_v = '0;
        endcase
        if (!sleep_i) begin
            s_d.sample = wave_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sample_o = s_q.sample;

endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core #(
    parameter int ACC_W    = 28,
    parameter int PHASE_W  = 12,
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [ACC_W-1:0]    wr_data,
    input  logic                freq_sel,
    input  logic                phase_sel,
    input  logic [1:0]          wave_mode,
    input  logic                sleep,
    output logic [ACC_W-1:0]    phase_acc_o,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam int TOP_LSB = ACC_W - PHASE_W;

    logic [1:0][ACC_W-1:0]   tune_w;
    logic [1:0][PHASE_W-1:0] offs_w;
    logic [ACC_W-1:0]        step_w;
    logic [ACC_W-1:0]        acc_w;
    logic [PHASE_W-1:0]      phase_w;

    dds_regfile #(
        .ACC_W   (ACC_W),
        .PHASE_W (PHASE_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tune_o  (tune_w),
        .offs_o  (offs_w)
    );

    always_comb begin
        step_w  = tune_w[freq_sel];
        phase_w = acc_w[ACC_W-1:TOP_LSB] + offs_w[phase_sel];
    end

    dds_accum #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .step_i (step_w),
        .acc_o  (acc_w)
    );

    dds_shaper #(
        .PHASE_W  (PHASE_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_shape (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase_w),
        .acc_msb_i (acc_w[ACC_W-1]),
        .mode_i    (wave_mode),
        .sleep_i   (sleep),
        .sample_o  (sample_o)
    );

    assign phase_acc_o = acc_w;

endmodule

// File: rtl/dds_wave_core_chk.sv
module dds_wave_core_chk #(
    parameter int ACC_W    = 28,
    parameter int PHASE_W  = 12,
    parameter int SAMPLE_W = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [ACC_W-1:0]    wr_data,
    input logic                freq_sel,
    input logic [1:0]          wave_mode,
    input logic                sleep,
    input logic [ACC_W-1:0]    tune_a,
    input logic [ACC_W-1:0]    tune_b,
    input logic [ACC_W-1:0]    phase_acc_o,
    input logic [SAMPLE_W-1:0] sample_o
);
    localparam logic [SAMPLE_W-1:0] FULL = {SAMPLE_W{1'b1}};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (phase_acc_o == '0 && sample_o == '0));

    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_acc_o == $past(phase_acc_o) + $past(freq_sel ? tune_b : tune_a));

    assert_write_tune_a_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> tune_a == $past(wr_data));

    assert_square_level_R8: assert property (@(posedge clk) disable iff (rst)
        (wave_mode == 2'd2 && !sleep) |=> sample_o == ($past(phase_acc_o[ACC_W-1]) ? FULL : '0));

    assert_half_square_levels_R9: assert property (@(posedge clk) disable iff (rst)
        (wave_mode == 2'd3 && !sleep) |=> (sample_o == '0 || sample_o == FULL));

    assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(sample_o));

endmodule

bind dds_wave_core dds_wave_core_chk #(
    .ACC_W    (ACC_W),
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .freq_sel    (freq_sel),
    .wave_mode   (wave_mode),
    .sleep       (sleep),
    .tune_a      (tune_w[0]),
    .tune_b      (tune_w[1]),
    .phase_acc_o (phase_acc_o),
    .sample_o    (sample_o)
);

// File: tb/dds_wave_core_tb_top.sv
module dds_wave_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [27:0] wr_data = '0;
    logic        freq_sel = 1'b0;
    logic        phase_sel = 1'b0;
    logic [1:0]  wave_mode = 2'd0;
    logic        sleep = 1'b0;
    logic [27:0] phase_acc_o;
    logic [9:0]  sample_o;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dds_wave_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .freq_sel    (freq_sel),
        .phase_sel   (phase_sel),
        .wave_mode   (wave_mode),
        .sleep       (sleep),
        .phase_acc_o (phase_acc_o),
        .sample_o    (sample_o)
    );

    typedef struct {
        int          due;
        logic [27:0] acc;
        logic [9:0]  samp;
        string       tag;
    } item_t;

    item_t sb[$];

    // Reference state, built from the requirements
    logic [27:0] m_acc = '0;
    logic [27:0] m_tune [2] = '{default: '0};
    logic [11:0] m_offs [2] = '{default: '0};
    logic        m_msbp = 1'b0;
    logic        m_tog = 1'b0;
    logic [9:0]  m_samp = '0;

    function automatic logic [9:0] sine_ref(input logic [11:0] pw);
        int i;
        int m;
        i = int'(pw[9:0]);
        if (pw[10]) i = 1023 - i;
        m = $rtoi(511.0 * $sin(3.141592653589793 * (2.0 * i + 1.0) / 4096.0) + 0.5);
        return pw[11] ? 10'(511 - m) : 10'(512 + m);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [1:0] wa, input logic [27:0] wd,
                        input bit fs, input bit ps, input logic [1:0] md,
                        input bit sl, input string tag);
        item_t it;
        logic [11:0] pw;
        logic [9:0]  wave;
        logic        tog_n;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        freq_sel = fs; phase_sel = ps; wave_mode = md; sleep = sl;
        pw    = m_acc[27:16] + m_offs[ps];
        tog_n = m_tog ^ (m_acc[27] & ~m_msbp);
        case (md)
            2'd0: wave = sine_ref(pw);
            2'd1: wave = pw[11] ? ~pw[10:1] : pw[10:1];
            2'd2: wave = {10{m_acc[27]}};
            default: wave = {10{tog_n}};
        endcase
        if (!sl) m_samp = wave;
        m_msbp = m_acc[27];
        m_tog  = tog_n;
        m_acc  = m_acc + m_tune[fs];
        if (we) begin
            if (wa[1]) m_offs[wa[0]] = wd[11:0];
            else       m_tune[wa[0]] = wd;
        end
        it.due = cyc + 1; it.acc = m_acc; it.samp = m_samp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic run(input int n, input bit fs, input bit ps, input logic [1:0] md,
                       input bit sl, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 2'd0, '0, fs, ps, md, sl, tag);
    endtask

    // Monitor: compares each prediction after its edge has passed
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, "phase_acc_o", int'(phase_acc_o), int'(it.acc));
            check(it.tag, "sample_o", int'(sample_o), int'(it.samp));
        end
    end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "phase_acc_o after reset", int'(phase_acc_o), 0);
        check("R1", "sample_o after reset", int'(sample_o), 0);
        @(negedge clk);
        rst = 1'b0;
        // R3: load tuning word A, R2 accumulation, R6 sine, R11 latency
        step(1'b1, 2'd0, 28'h0100000, 1'b0, 1'b0, 2'd0, 1'b0, "R3");
        run(70, 1'b0, 1'b0, 2'd0, 1'b0, "R6");
        // R4: tuning word B with a wrap-prone value
        step(1'b1, 2'd1, 28'h1234567, 1'b0, 1'b0, 2'd0, 1'b0, "R3");
        run(30, 1'b1, 1'b0, 2'd0, 1'b0, "R4");
        run(5, 1'b0, 1'b0, 2'd0, 1'b0, "R4");
        // R2: zero tuning word holds the accumulator
        step(1'b1, 2'd0, 28'h0000000, 1'b0, 1'b0, 2'd0, 1'b0, "R2");
        run(8, 1'b0, 1'b0, 2'd0, 1'b0, "R2");
        // R5: offsets, including wrap of the 12-bit sum
        step(1'b1, 2'd3, 28'h0000800, 1'b0, 1'b0, 2'd0, 1'b0, "R3");
        step(1'b1, 2'd2, 28'hFFFFFFF, 1'b1, 1'b1, 2'd0, 1'b0, "R5");
        run(20, 1'b1, 1'b1, 2'd0, 1'b0, "R5");
        run(20, 1'b1, 1'b0, 2'd0, 1'b0, "R5");
        // R7: triangle
        run(60, 1'b1, 1'b0, 2'd1, 1'b0, "R7");
        // R8: square on the MSB
        step(1'b1, 2'd0, 28'h1000000, 1'b0, 1'b0, 2'd2, 1'b0, "R8");
        run(50, 1'b0, 1'b0, 2'd2, 1'b0, "R8");
        // R9: half-rate square
        run(80, 1'b0, 1'b0, 2'd3, 1'b0, "R9");
        // R10: sleep freezes the sample, accumulator keeps going
        run(12, 1'b0, 1'b0, 2'd2, 1'b1, "R10");
        run(6, 1'b0, 1'b0, 2'd2, 1'b0, "R10");
        run(8, 1'b1, 1'b0, 2'd0, 1'b1, "R10");
        run(10, 1'b1, 1'b0, 2'd1, 1'b0, "R11");
        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule